// File: doc/BRIEF.md
# Small-Image Raster Display Controller

This block drives a standard analog monitor from a small stored picture. Two free-running counters track the beam. The column counter advances on every pixel clock. The line counter advances once at the end of each line. The block decodes both sync pulses and the visible area from these counters.

A rectangular image window sits at a chosen offset inside the visible area. By default the image is 120 by 90 pixels, placed at the top-left corner. While the beam is inside that window, the block presents a linear read address to an external synchronous pixel memory. Each memory word holds 3 bits, one on/off bit for each of red, green and blue. The memory returns the word one clock later. The sync and window flags are delayed by one register, so the returned colour lands on the correct pixel. Outside the window, and throughout blanking, the colour lines are held at zero.

The default timing is 640x480 at 60 Hz on a 25 MHz pixel clock: 800 clocks per line and 525 lines per frame, with both syncs active low. Every timing span, the image size and the image offset are parameters.

Top module: `pixel_raster_display`

## Requirements
- R1: The column counter counts 0 to H_TOTAL-1 on every clock and wraps, so consecutive falling edges of `hsync_n` are exactly H_TOTAL clocks apart.
- R2: The line counter advances only on the clock where the column counter wraps, so each vertical sync pulse spans exactly V_SYNC falling edges of `hsync_n`.
- R3: `hsync_n` is 0 (active low) for column positions H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC-1, and 1 otherwise. It appears one clock after the counters hold that position.
- R4: `vsync_n` is 0 for line positions V_ACTIVE+V_FRONT up to V_ACTIVE+V_FRONT+V_SYNC-1, and 1 otherwise. It has the same one-clock delay as R3.
- R5: In the same cycle as the counters, `mem_addr` equals (line-IMG_Y0)*IMG_W + (column-IMG_X0) when the column is in [IMG_X0, IMG_X0+IMG_W) and the line is in [IMG_Y0, IMG_Y0+IMG_H). Otherwise `mem_addr` is 0.
- R6: For a position inside the image window, one clock later `red`, `green` and `blue` equal bits 2, 1 and 0 of the memory word. That word is the one the memory returns for the address issued at that position, with one clock of read latency.
- R7: For a visible position outside the image window, the three colour outputs are 0 one clock later.
- R8: For any position in horizontal or vertical blanking, the three colour outputs are 0 one clock later.
- R9: While `rst_n` is low, `hsync_n` and `vsync_n` are 1 and the colours are 0. On the first clock after release, the outputs show position (column 0, line 0).
- R10: After line V_TOTAL-1 ends, the line counter returns to 0, so consecutive falling edges of `vsync_n` are H_TOTAL*V_TOTAL clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Linear pixel read address (0 outside the image window) |
| mem_data | input | 3 | Pixel word returned one clock after the address: bit 2 red, bit 1 green, bit 0 blue |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red on/off |
| green | output | 1 | Green on/off |
| blue | output | 1 | Blue on/off |

## Verification
The bench builds the block with a shrunken raster:
- 28 clocks per line: 20 visible, 2 front porch, 3 sync, 3 back porch.
- 17 lines per frame: 12 visible, 1 front porch, 2 sync, 2 back porch.
- An 8 by 5 image at column offset 3 and line offset 4.

A whole frame is then only 476 clocks. Several complete frames, the frame wrap and a mid-frame reset therefore fit in a short run. The nonzero offsets keep the window clear of every edge of the visible area, so visible-but-outside-window pixels exist on all four sides of the image. The memory model derives each word from its address, so a wrong address or a misaligned delay shows up as a wrong colour.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int PIX_BITS = 3;

  function automatic logic in_span(int pos, int lo, int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  function automatic int lin_index(int row, int col, int width);
    return row * width + col;
  endfunction

endpackage

// File: rtl/prd_axis_counter.sv
module prd_axis_counter #(
  parameter int LIMIT = 800,
  parameter int CW    = $clog2(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] value,
  output logic          last
);

  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  assign last = (value == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (step) begin
      value <= last ? '0 : value + 1'b1;
    end
  end

endmodule

// File: rtl/prd_span_decode.sv
module prd_span_decode #(
  parameter int ACTIVE = 640,
  parameter int FRONT  = 16,
  parameter int SYNC   = 96,
  parameter int CW     = 10
) (
  input  logic [CW-1:0] pos,
  output logic          visible,
  output logic          sync_on
);
  import prd_pkg::*;

  localparam int SYNC_START = ACTIVE + FRONT;

  always_comb begin
    visible = in_span(int'(pos), 0, ACTIVE);
    sync_on = in_span(int'(pos), SYNC_START, SYNC);
  end

endmodule

// File: rtl/prd_window_addr.sv
module prd_window_addr #(
  parameter int IMG_W  = 120,
  parameter int IMG_H  = 90,
  parameter int IMG_X0 = 0,
  parameter int IMG_Y0 = 0,
  parameter int HCW    = 10,
  parameter int VCW    = 10,
  parameter int ADDR_W = 14
) (
  input  logic [HCW-1:0]    hpos,
  input  logic [VCW-1:0]    vpos,
  output logic              in_win,
  output logic [ADDR_W-1:0] addr
);
  import prd_pkg::*;

  int col_rel;
  int row_rel;

  always_comb begin
    col_rel = int'(hpos) - IMG_X0;
    row_rel = int'(vpos) - IMG_Y0;
    in_win  = in_span(int'(hpos), IMG_X0, IMG_W) && in_span(int'(vpos), IMG_Y0, IMG_H);
    addr    = in_win ? ADDR_W'(lin_index(row_rel, col_rel, IMG_W)) : '0;
  end

endmodule

// File: rtl/prd_out_stage.sv
module prd_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_on,
  input  logic       vs_on,
  input  logic       visible,
  input  logic       in_win,
  input  logic [2:0] mem_data,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       red,
  output logic       green,
  output logic       blue
);

  logic hs_q;
  logic vs_q;
  logic show_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      show_q <= 1'b0;
    end else begin
      hs_q   <= hs_on;
      vs_q   <= vs_on;
      show_q <= in_win && visible;
    end
  end

  assign hsync_n = !hs_q;
  assign vsync_n = !vs_q;
  assign red     = show_q & mem_data[2];
  assign green   = show_q & mem_data[1];
  assign blue    = show_q & mem_data[0];

endmodule

// File: rtl/pixel_raster_display.sv
module pixel_raster_display #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int IMG_W    = 120,
  parameter int IMG_H    = 90,
  parameter int IMG_X0   = 0,
  parameter int IMG_Y0   = 0,
  parameter int ADDR_W   = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [2:0]        mem_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              red,
  output logic              green,
  output logic              blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HCW     = $clog2(H_TOTAL);
  localparam int VCW     = $clog2(V_TOTAL);

  logic [HCW-1:0] hpos;
  logic [VCW-1:0] vpos;
  logic           h_last;
  logic           v_last;
  logic           h_visible;
  logic           v_visible;
  logic           h_sync_on;
  logic           v_sync_on;
  logic           in_win;

  prd_axis_counter #(.LIMIT(H_TOTAL), .CW(HCW)) i_hcnt (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .value(hpos), .last(h_last)
  );

  prd_axis_counter #(.LIMIT(V_TOTAL), .CW(VCW)) i_vcnt (
    .clk(clk), .rst_n(rst_n), .step(h_last), .value(vpos), .last(v_last)
  );

  prd_span_decode #(.ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .CW(HCW)) i_hdec (
    .pos(hpos), .visible(h_visible), .sync_on(h_sync_on)
  );

  prd_span_decode #(.ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .CW(VCW)) i_vdec (
    .pos(vpos), .visible(v_visible), .sync_on(v_sync_on)
  );

  prd_window_addr #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .IMG_X0(IMG_X0), .IMG_Y0(IMG_Y0),
    .HCW(HCW), .VCW(VCW), .ADDR_W(ADDR_W)
  ) i_win (
    .hpos(hpos), .vpos(vpos), .in_win(in_win), .addr(mem_addr)
  );

  prd_out_stage i_out (
    .clk(clk), .rst_n(rst_n),
    .hs_on(h_sync_on), .vs_on(v_sync_on),
    .visible(h_visible && v_visible), .in_win(in_win),
    .mem_data(mem_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );

endmodule

// File: rtl/pixel_raster_display_chk.sv
module pixel_raster_display_chk #(
  parameter int HCW     = 10,
  parameter int VCW     = 10,
  parameter int ADDR_W  = 14,
  parameter int IMG_PIX = 10800
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HCW-1:0]    hpos,
  input logic [VCW-1:0]    vpos,
  input logic              h_last,
  input logic              v_last,
  input logic              h_visible,
  input logic              v_visible,
  input logic              h_sync_on,
  input logic              v_sync_on,
  input logic              in_win,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              red,
  input logic              green,
  input logic              blue
);

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n) !h_last |=> hpos == $past(hpos) + 1'b1); // R1
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n) h_last |=> hpos == '0); // R1
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !h_last |=> $stable(vpos)); // R2
  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (h_last && v_last) |=> vpos == '0); // R10
  AST_HS_ON: assert property (@(posedge clk) disable iff (!rst_n) h_sync_on |=> !hsync_n); // R3
  AST_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n) !h_sync_on |=> hsync_n); // R3
  AST_VS_ON: assert property (@(posedge clk) disable iff (!rst_n) v_sync_on |=> !vsync_n); // R4
  AST_VS_OFF: assert property (@(posedge clk) disable iff (!rst_n) !v_sync_on |=> vsync_n); // R4
  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_win |-> mem_addr == '0); // R5
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(mem_addr) < IMG_PIX); // R5
  AST_BLACK_OUT: assert property (@(posedge clk) disable iff (!rst_n) !in_win |=> (red || green || blue) == 1'b0); // R7
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n) !(h_visible && v_visible) |=> (red || green || blue) == 1'b0); // R8

endmodule

bind pixel_raster_display pixel_raster_display_chk #(
  .HCW(HCW), .VCW(VCW), .ADDR_W(ADDR_W), .IMG_PIX(IMG_W * IMG_H)
) i_chk (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
  .h_last(h_last), .v_last(v_last),
  .h_visible(h_visible), .v_visible(v_visible),
  .h_sync_on(h_sync_on), .v_sync_on(v_sync_on),
  .in_win(in_win), .mem_addr(mem_addr),
  .hsync_n(hsync_n), .vsync_n(vsync_n),
  .red(red), .green(green), .blue(blue)
);

// File: tb/test_pixel_raster_display.sv
module test_pixel_raster_display;
  localparam int HA = 20, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int IW = 8, IH = 5, X0 = 3, Y0 = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int AW = $clog2(IW * IH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [2:0]    mem_data = 3'b000;
  logic          hsync_n, vsync_n, red, green, blue;
  int            checks = 0;
  int            fails = 0;
  int            t = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  pixel_raster_display #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .IMG_W(IW), .IMG_H(IH), .IMG_X0(X0), .IMG_Y0(Y0)
  ) i_pixel_raster_display (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [2:0] pat(int a);
    int x;
    x = a * 13 + (a >> 2) + 5;
    return 3'(x ^ (x >> 3));
  endfunction

  // synchronous memory model with one clock of latency
  always @(posedge clk) begin
    mem_data <= pat(int'(mem_addr));
    if (!rst_n) t <= 0;
    else        t <= t + 1;
  end

  function automatic int hof(int p); return p % HT; endfunction
  function automatic int vof(int p); return (p / HT) % VT; endfunction
  function automatic bit inw(int h, int v);
    return h >= X0 && h < X0 + IW && v >= Y0 && v < Y0 + IH;
  endfunction
  function automatic int exp_addr(int p);
    return inw(hof(p), vof(p)) ? (vof(p) - Y0) * IW + hof(p) - X0 : 0;
  endfunction
  function automatic int exp_rgb(int p);
    return inw(hof(p), vof(p)) ? int'(pat(exp_addr(p))) : 0;
  endfunction
  function automatic int exp_hs(int p);
    return (hof(p) >= HA + HF && hof(p) < HA + HF + HS) ? 0 : 1;
  endfunction
  function automatic int exp_vs(int p);
    return (vof(p) >= VA + VF && vof(p) < VA + VF + VS) ? 0 : 1;
  endfunction
  function automatic int rgb();
    return int'({red, green, blue});
  endfunction
  function automatic int outpos();
    return (t - 1) % FRAME;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0d", req, what, act, exp, t);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "hsync_n in reset", int'(hsync_n), 1);
    check("R9", "vsync_n in reset", int'(vsync_n), 1);
    check("R9", "colour in reset", rgb(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "first hsync_n", int'(hsync_n), exp_hs(0));
    check("R9", "first vsync_n", int'(vsync_n), exp_vs(0));
    check("R9", "first colour", rgb(), exp_rgb(0));
    check("R9", "first address", int'(mem_addr), exp_addr(1));
  endtask

  task automatic t_hsync(int lines);
    int last_fall = -1;
    int low_run = 0;
    logic prev = hsync_n;
    for (int i = 0; i < lines * HT; i++) begin
      @(negedge clk);
      check("R3", "hsync_n", int'(hsync_n), exp_hs(outpos()));
      if (!hsync_n) low_run++;
      if (prev && !hsync_n) begin
        if (last_fall >= 0) check("R1", "hsync period", t - last_fall, HT);
        last_fall = t;
      end
      if (!prev && hsync_n) begin
        check("R3", "hsync width", low_run, HS);
        low_run = 0;
      end
      prev = hsync_n;
    end
  endtask

  task automatic t_vsync();
    int hs_falls = 0;
    logic prev_v = vsync_n;
    logic prev_h = hsync_n;
    for (int i = 0; i < FRAME + HT; i++) begin
      @(negedge clk);
      check("R4", "vsync_n", int'(vsync_n), exp_vs(outpos()));
      if (!vsync_n && prev_h && !hsync_n) hs_falls++;
      if (!prev_v && vsync_n) begin
        check("R2", "lines in vsync", hs_falls, VS);
        hs_falls = 0;
      end
      prev_v = vsync_n;
      prev_h = hsync_n;
    end
  endtask

  task automatic t_addr();
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      check("R5", "mem_addr", int'(mem_addr), exp_addr(t % FRAME));
    end
  endtask

  task automatic t_pixels(int cycles);
    for (int i = 0; i < cycles; i++) begin
      int p, h, v;
      @(negedge clk);
      p = outpos();
      h = hof(p);
      v = vof(p);
      if (inw(h, v))               check("R6", "window colour", rgb(), exp_rgb(p));
      else if (h >= HA || v >= VA) check("R8", "blanking colour", rgb(), 0);
      else                         check("R7", "outside colour", rgb(), 0);
    end
  endtask

  task automatic t_wrap();
    int first = -1;
    logic prev = vsync_n;
    for (int i = 0; i < 3 * FRAME; i++) begin
      @(negedge clk);
      if (prev && !vsync_n) begin
        if (first >= 0) begin
          check("R10", "frame period", t - first, FRAME);
          break;
        end
        first = t;
      end
      prev = vsync_n;
    end
  endtask

  task automatic t_midreset();
    repeat (FRAME / 2 + 7) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "hsync_n mid reset", int'(hsync_n), 1);
    check("R9", "vsync_n mid reset", int'(vsync_n), 1);
    check("R9", "colour mid reset", rgb(), 0);
    rst_n = 1'b1;
    t_pixels(FRAME);
  endtask

  initial begin : wd
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hsync(3);
    t_vsync();
    t_addr();
    t_pixels(FRAME);
    t_wrap();
    t_midreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule